// File: doc/BRIEF.md
# Shadowed-Period Asymmetric PWM Timer

This block produces one pulse-width-modulated output from an up-counting time base. Software programs a period value and a compare value through a small word-addressed register bus. The counter runs from zero up to the period value and then returns to zero, so one output period lasts period+1 clock cycles. In normal polarity the output is high while the count is below the compare value. An inversion bit flips the output, so the compare value then sets the low time. A mode bit gates the waveform, and the output is held low while that bit is clear.

Each of the two timing values has an active copy and a shadow copy. A write to an active copy takes effect on the next clock, which suits a timer that is stopped. A write to a shadow copy is held as pending. It moves into the active copy only on the cycle the counter wraps, so a period in progress always runs to its end. An optional synchronous reload input sets the counter back to zero. A two-bit field in the control register can switch this input off.

Top module: `apwm_timer`

## Requirements
- R1: After reset every register reads 0, the counter is stopped and `pwm_out` is 0.
- R2: Register map (byte addresses): 0x00 active period, 0x04 active compare, 0x08 shadow period, 0x0C shadow compare, 0x10 control. Control bit 0 is run, bit 1 is PWM mode, bit 2 is invert, and bits 4:3 select sync (binary 11 disables it). Control bits above 4 are not stored and read 0. Any other address reads 0, and a write to it has no effect.
- R3: While run is set, the counter advances by one each clock. On the clock after the count has reached or passed the active period, it returns to 0. One period therefore lasts period+1 clocks.
- R4: While run is clear, the counter holds its value, and sync pulses are ignored.
- R5: With mode set and invert clear, `pwm_out` is 1 exactly when count < active compare.
- R6: A compare value at or above the period gives a constant high output (in normal polarity). This includes period=1 with compare=1. A compare of 0 with a nonzero period gives a constant low output.
- R7: With invert set, `pwm_out` is the complement of the normal-polarity waveform.
- R8: While mode is clear, `pwm_out` is 0 whatever the polarity, count or compare value.
- R9: A write to a shadow register marks it pending. The active copy keeps its old value until the first wrap clock, and on that clock it takes the shadow value and clears the pending mark. A shadow with no pending mark is never copied.
- R10: A write to an active register changes it on the next clock, and the waveform follows at once.
- R11: With sync enabled (bits 4:3 not 11) and run set, a high `sync_in` sets the counter to 0 on the next clock. With bits 4:3 = 11, `sync_in` has no effect.
- R12: Collisions at a wrap clock. A shadow write on the wrap clock is not transferred by that wrap and stays pending for the next one. An active write on a wrap clock with a pending shadow wins, and the pending mark is cleared. A sync pulse on the wrap clock does not block the transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_we | input | 1 | Write strobe for the register bus |
| bus_addr | input | 6 | Byte address for write and read |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| sync_in | input | 1 | Synchronous counter reload pulse |
| pwm_out | output | 1 | PWM waveform |

## Verification
The shadow-to-active transfer at the period wrap can fall in the same clock as a bus write to the shadow or active register, and in the same clock as a sync pulse. The bench keeps its own reference count. It uses that count to place a write or a sync pulse exactly on the clock where the wrap happens. It then compares the readback of the active registers and the waveform against the model on every following clock. The right outcome is the priority set out in R12: the write survives, the newly written shadow stays pending, and the transfer happens despite the sync pulse.

// File: rtl/apwm_pkg.sv
package apwm_pkg;

   // byte addresses of the register file
   localparam int unsigned ACT_BASE  = 'h00;  // + 4*slot
   localparam int unsigned SHD_BASE  = 'h08;  // + 4*slot
   localparam int unsigned CTRL_ADDR = 'h10;

   // slot indices of the shadowed timing values
   localparam int unsigned SLOT_PER  = 0;
   localparam int unsigned SLOT_CMP  = 1;
   localparam int unsigned NSLOT     = 2;

   localparam logic [1:0] SYNC_OFF = 2'b11;

   typedef struct packed {
      logic [1:0] sync_sel;  // bits 4:3
      logic       inv;       // bit 2
      logic       mode;      // bit 1
      logic       run;       // bit 0
   } ctrl_t;

   localparam int unsigned CTRL_W = $bits(ctrl_t);

endpackage

// File: rtl/apwm_shadow_reg.sv
module apwm_shadow_reg #(
   parameter int unsigned W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr_act,
   input  logic         wr_shd,
   input  logic [W-1:0] wdata,
   input  logic         wrap,
   output logic [W-1:0] act,
   output logic [W-1:0] shd,
   output logic         pend
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act  <= '0;
         shd  <= '0;
         pend <= 1'b0;
      end else begin
         // transfer first; later assignments in this block take priority
         if (wrap && pend) begin
            act  <= shd;
            pend <= 1'b0;
         end
         if (wr_act) begin
            act <= wdata;
         end
         if (wr_shd) begin
            shd  <= wdata;
            pend <= 1'b1;
         end
      end
   end

endmodule

// File: rtl/apwm_regs.sv
module apwm_regs
   import apwm_pkg::*;
#(
   parameter int unsigned CNT_W  = 32,
   parameter int unsigned ADDR_W = 6,
   parameter int unsigned DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              wrap,
   output logic [DATA_W-1:0] rdata,
   output ctrl_t             ctrl,
   output logic [CNT_W-1:0]  per_act,
   output logic [CNT_W-1:0]  cmp_act,
   output logic [CNT_W-1:0]  per_shd,
   output logic              per_pend,
   output logic              per_wr
);

   logic [CNT_W-1:0] act_v  [NSLOT];
   logic [CNT_W-1:0] shd_v  [NSLOT];
   logic             pend_v [NSLOT];
   logic             wr_a   [NSLOT];
   logic             wr_s   [NSLOT];
   ctrl_t            ctrl_q;
   logic             ctrl_wr;

   for (genvar s = 0; s < NSLOT; s++) begin : g_slot
      localparam logic [ADDR_W-1:0] A_ACT = ADDR_W'(ACT_BASE + 4 * s);
      localparam logic [ADDR_W-1:0] A_SHD = ADDR_W'(SHD_BASE + 4 * s);

      assign wr_a[s] = we && (addr == A_ACT);
      assign wr_s[s] = we && (addr == A_SHD);

      apwm_shadow_reg #(.W(CNT_W)) u_sreg (
         .clk    (clk),
         .rst_n  (rst_n),
         .wr_act (wr_a[s]),
         .wr_shd (wr_s[s]),
         .wdata  (wdata[CNT_W-1:0]),
         .wrap   (wrap),
         .act    (act_v[s]),
         .shd    (shd_v[s]),
         .pend   (pend_v[s])
      );
   end

   assign ctrl_wr = we && (addr == ADDR_W'(CTRL_ADDR));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
      end else if (ctrl_wr) begin
         ctrl_q <= ctrl_t'(wdata[CTRL_W-1:0]);
      end
   end

   always_comb begin
      rdata = '0;
      for (int s = 0; s < NSLOT; s++) begin
         if (addr == ADDR_W'(ACT_BASE + 4 * s)) rdata = DATA_W'(act_v[s]);
         if (addr == ADDR_W'(SHD_BASE + 4 * s)) rdata = DATA_W'(shd_v[s]);
      end
      if (addr == ADDR_W'(CTRL_ADDR)) rdata = DATA_W'(ctrl_q);
   end

   assign ctrl     = ctrl_q;
   assign per_act  = act_v[SLOT_PER];
   assign cmp_act  = act_v[SLOT_CMP];
   assign per_shd  = shd_v[SLOT_PER];
   assign per_pend = pend_v[SLOT_PER];
   assign per_wr   = wr_a[SLOT_PER];

endmodule

// File: rtl/apwm_counter.sv
module apwm_counter #(
   parameter int unsigned CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             reload,
   input  logic [CNT_W-1:0] period,
   output logic [CNT_W-1:0] cnt,
   output logic             wrap
);

   // >= keeps a count left above a lowered period from running away
   assign wrap = run && (cnt >= period);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (run) begin
         if (reload || wrap) cnt <= '0;
         else                cnt <= cnt + 1'b1;
      end
   end

endmodule

// File: rtl/apwm_wave.sv
module apwm_wave #(
   parameter int unsigned CNT_W = 32
) (
   input  logic [CNT_W-1:0] cnt,
   input  logic [CNT_W-1:0] per,
   input  logic [CNT_W-1:0] cmp,
   input  logic             mode,
   input  logic             inv,
   output logic             level
);

   logic active_hi;

   // compare at or beyond the period saturates to a full-high cycle
   assign active_hi = (cmp >= per) || (cnt < cmp);
   assign level     = mode && (active_hi ^ inv);

endmodule

// File: rtl/apwm_timer.sv
module apwm_timer
   import apwm_pkg::*;
#(
   parameter int unsigned CNT_W   = 32,
   parameter int unsigned ADDR_W  = 6,
   parameter int unsigned DATA_W  = 32,
   parameter bit          OUT_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              sync_in,
   output logic              pwm_out
);

   if (CNT_W < 2 || CNT_W > DATA_W) begin : g_bad_cnt_w
      $error("apwm_timer: CNT_W must lie in 2..DATA_W");
   end
   if (ADDR_W < 5) begin : g_bad_addr_w
      $error("apwm_timer: ADDR_W must be at least 5");
   end

   ctrl_t            ctrl;
   logic [CNT_W-1:0] per_act;
   logic [CNT_W-1:0] cmp_act;
   logic [CNT_W-1:0] per_shd;
   logic             per_pend;
   logic             per_wr;
   logic [CNT_W-1:0] cnt_q;
   logic             wrap;
   logic             sync_hit;
   logic             level;

   assign sync_hit = sync_in && (ctrl.sync_sel != SYNC_OFF);

   apwm_regs #(.CNT_W(CNT_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .we       (bus_we),
      .addr     (bus_addr),
      .wdata    (bus_wdata),
      .wrap     (wrap),
      .rdata    (bus_rdata),
      .ctrl     (ctrl),
      .per_act  (per_act),
      .cmp_act  (cmp_act),
      .per_shd  (per_shd),
      .per_pend (per_pend),
      .per_wr   (per_wr)
   );

   apwm_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk    (clk),
      .rst_n  (rst_n),
      .run    (ctrl.run),
      .reload (sync_hit),
      .period (per_act),
      .cnt    (cnt_q),
      .wrap   (wrap)
   );

   apwm_wave #(.CNT_W(CNT_W)) u_wave (
      .cnt   (cnt_q),
      .per   (per_act),
      .cmp   (cmp_act),
      .mode  (ctrl.mode),
      .inv   (ctrl.inv),
      .level (level)
   );

   if (OUT_REG) begin : g_out_flop
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) pwm_out <= 1'b0;
         else        pwm_out <= level;
      end
   end else begin : g_out_comb
      assign pwm_out = level;
   end

endmodule

// File: rtl/apwm_timer_chk.sv
module apwm_timer_chk #(
   parameter int unsigned CNT_W   = 32,
   parameter bit          OUT_REG = 1'b0
) (
   input logic             clk,
   input logic             rst_n,
   input logic             run,
   input logic             mode,
   input logic [1:0]       sync_sel,
   input logic             sync_in,
   input logic [CNT_W-1:0] cnt,
   input logic [CNT_W-1:0] per,
   input logic [CNT_W-1:0] sper,
   input logic             pend_per,
   input logic             wr_per,
   input logic             wrap,
   input logic             pwm_out
);

   logic sync_on;
   assign sync_on = sync_in && (sync_sel != 2'b11);

   if (OUT_REG) begin : g_lag
      a_r8_mode_low: assert property (@(posedge clk) disable iff (!rst_n)
         !mode |=> !pwm_out);
   end else begin : g_now
      a_r8_mode_low: assert property (@(posedge clk) disable iff (!rst_n)
         !mode |-> !pwm_out);
   end

   a_r4_stop_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> $stable(cnt));

   a_r3_wrap_zero: assert property (@(posedge clk) disable iff (!rst_n)
      wrap |=> (cnt == '0));

   a_r3_step_one: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !wrap && !sync_on) |=> (cnt == $past(cnt) + 1'b1));

   a_r11_sync_reload: assert property (@(posedge clk) disable iff (!rst_n)
      (run && sync_on) |=> (cnt == '0));

   a_r9_shadow_load: assert property (@(posedge clk) disable iff (!rst_n)
      (wrap && pend_per && !wr_per) |=> (per == $past(sper)));

   a_r9_no_early_load: assert property (@(posedge clk) disable iff (!rst_n)
      (!wrap && !wr_per) |=> $stable(per));

endmodule

bind apwm_timer apwm_timer_chk #(.CNT_W(CNT_W), .OUT_REG(OUT_REG)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .run      (ctrl.run),
   .mode     (ctrl.mode),
   .sync_sel (ctrl.sync_sel),
   .sync_in  (sync_in),
   .cnt      (cnt_q),
   .per      (per_act),
   .sper     (per_shd),
   .pend_per (per_pend),
   .wr_per   (per_wr),
   .wrap     (wrap),
   .pwm_out  (pwm_out)
);

// File: tb/apwm_timer_tb.sv
module apwm_timer_tb_top;

   localparam logic [5:0] A_PER  = 6'h00;
   localparam logic [5:0] A_CMP  = 6'h04;
   localparam logic [5:0] A_SPER = 6'h08;
   localparam logic [5:0] A_SCMP = 6'h0C;
   localparam logic [5:0] A_CTRL = 6'h10;

   localparam logic [31:0] C_RUN    = 32'h01;
   localparam logic [31:0] C_MODE   = 32'h02;
   localparam logic [31:0] C_INV    = 32'h04;
   localparam logic [31:0] C_NOSYNC = 32'h18;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_we = 1'b0;
   logic [5:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        sync_in = 1'b0;
   logic        pwm_out;

   int    total = 0;
   int    bad = 0;
   int    cycles = 0;
   bit    done = 1'b0;
   string cur_req = "R1";
   int    rot = 0;

   // reference model state
   logic [31:0] m_act [2];
   logic [31:0] m_shd [2];
   bit          m_pend [2];
   logic [4:0]  m_ctrl;
   logic [31:0] m_cnt;

   always #4 clk = ~clk;

   apwm_timer dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_we    (bus_we),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .sync_in   (sync_in),
      .pwm_out   (pwm_out)
   );

   initial begin
      for (int i = 0; i < 2; i++) begin
         m_act[i] = '0; m_shd[i] = '0; m_pend[i] = 1'b0;
      end
      m_ctrl = '0;
      m_cnt  = '0;
   end

   function automatic logic [31:0] exp_rdata(logic [5:0] a);
      case (a)
         A_PER:   return m_act[0];
         A_CMP:   return m_act[1];
         A_SPER:  return m_shd[0];
         A_SCMP:  return m_shd[1];
         A_CTRL:  return {27'd0, m_ctrl};
         default: return 32'd0;
      endcase
   endfunction

   function automatic logic exp_pwm();
      logic hi;
      if (!m_ctrl[1]) return 1'b0;
      hi = (m_act[1] >= m_act[0]) || (m_cnt < m_act[1]);
      return m_ctrl[2] ? !hi : hi;
   endfunction

   // model advances on the same edge as the design
   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < 2; i++) begin
            m_act[i] = '0; m_shd[i] = '0; m_pend[i] = 1'b0;
         end
         m_ctrl = '0;
         m_cnt  = '0;
      end else begin
         bit wrap_now;
         wrap_now = m_ctrl[0] && (m_cnt >= m_act[0]);
         if (m_ctrl[0]) begin
            if ((sync_in && m_ctrl[4:3] != 2'b11) || wrap_now) m_cnt = 0;
            else m_cnt = m_cnt + 1;
         end
         for (int i = 0; i < 2; i++) begin
            if (wrap_now && m_pend[i]) begin
               m_act[i]  = m_shd[i];
               m_pend[i] = 1'b0;
            end
         end
         if (bus_we) begin
            case (bus_addr)
               A_PER:  m_act[0] = bus_wdata;
               A_CMP:  m_act[1] = bus_wdata;
               A_SPER: begin m_shd[0] = bus_wdata; m_pend[0] = 1'b1; end
               A_SCMP: begin m_shd[1] = bus_wdata; m_pend[1] = 1'b1; end
               A_CTRL: m_ctrl = bus_wdata[4:0];
               default: ;
            endcase
         end
      end
   end

   task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s: actual=0x%0h expected=0x%0h at cycle %0d",
                  cur_req, what, act, exp, cycles);
      end
   endtask

   task automatic summary();
      if (!done) begin
         done = 1'b1;
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   endtask

   // compare every cycle, away from both edges
   always @(negedge clk) begin
      #2;
      if (!done) begin
         chk("pwm_out", {31'd0, pwm_out}, {31'd0, exp_pwm()});
         chk("rdata", bus_rdata, exp_rdata(bus_addr));
      end
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 20000 && !done) begin
         total++;
         bad++;
         $display("FAIL watchdog: actual=%0d expected<=20000 cycles", cycles);
         summary();
      end
   end

   function automatic logic [5:0] rot_addr(int k);
      case (k % 7)
         0: return A_PER;
         1: return A_CMP;
         2: return A_SPER;
         3: return A_SCMP;
         4: return A_CTRL;
         5: return 6'h14;
         default: return 6'h3C;
      endcase
   endfunction

   // all tasks start and end at a falling edge
   task automatic idle(int n);
      repeat (n) begin
         bus_addr = rot_addr(rot);
         rot++;
         @(negedge clk);
      end
   endtask

   task automatic wr(logic [5:0] a, logic [31:0] d);
      bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic pulse_sync();
      sync_in = 1'b1;
      @(negedge clk);
      sync_in = 1'b0;
   endtask

   task automatic wait_wrap();
      while (!(m_ctrl[0] && m_cnt >= m_act[0])) @(negedge clk);
   endtask

   initial begin
      // R1: reset state
      cur_req = "R1";
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      idle(14);

      // R2: map, upper control bits, unmapped addresses
      cur_req = "R2";
      wr(6'h14, 32'h1234);
      wr(6'h3C, 32'h55);
      idle(7);
      wr(A_SPER, 32'd9);
      wr(A_SCMP, 32'd4);
      wr(A_PER, 32'd9);
      wr(A_CMP, 32'd4);
      wr(A_CTRL, 32'hFFE0);
      idle(7);

      // R3 and R5: counting and normal waveform
      cur_req = "R3";
      wr(A_CTRL, C_RUN | C_MODE);
      idle(25);
      cur_req = "R5";
      idle(20);

      // R4: stop holds the count
      cur_req = "R4";
      wr(A_CTRL, C_MODE);
      idle(6);
      pulse_sync();
      idle(4);
      wr(A_CTRL, C_RUN | C_MODE);
      idle(6);

      // R7: inverted polarity
      cur_req = "R7";
      wr(A_CTRL, C_RUN | C_MODE | C_INV);
      idle(30);

      // R8: mode clear forces low in both polarities
      cur_req = "R8";
      wr(A_CTRL, C_RUN | C_INV);
      idle(12);
      wr(A_CTRL, C_RUN);
      idle(12);

      // R6: saturated and empty compare, minimum period
      cur_req = "R6";
      wr(A_CTRL, C_RUN | C_MODE);
      wr(A_CMP, 32'd12);
      idle(25);
      wr(A_PER, 32'd1);
      wr(A_CMP, 32'd1);
      idle(10);
      wr(A_PER, 32'd5);
      wr(A_CMP, 32'd0);
      idle(15);

      // R9: shadow loads only at the wrap
      cur_req = "R9";
      wr(A_PER, 32'd9);
      wr(A_CMP, 32'd3);
      idle(5);
      wr(A_SPER, 32'd5);
      wr(A_SCMP, 32'd2);
      idle(40);

      // R10: active writes take effect at once
      cur_req = "R10";
      wr(A_CMP, 32'd7);
      idle(12);
      wr(A_PER, 32'd12);
      idle(20);

      // R11: sync reload enabled, then disabled
      cur_req = "R11";
      idle(3);
      pulse_sync();
      idle(8);
      pulse_sync();
      idle(3);
      wr(A_CTRL, C_RUN | C_MODE | C_NOSYNC);
      idle(3);
      pulse_sync();
      idle(12);

      // R12: collisions on the wrap clock
      cur_req = "R12";
      wr(A_CTRL, C_RUN | C_MODE);
      wr(A_PER, 32'd7);
      wr(A_CMP, 32'd3);
      wait_wrap();
      wr(A_SPER, 32'd4);
      idle(20);
      wr(A_SPER, 32'd10);
      wait_wrap();
      wr(A_PER, 32'd9);
      idle(25);
      wr(A_SPER, 32'd6);
      wait_wrap();
      pulse_sync();
      idle(20);

      summary();
   end

endmodule